// File: doc/BRIEF.md
# OTG Host-Negotiation Role-Swap Controller

This block steps a dual-role OTG port through the hand-over of the host role between the two ends of a link. When strapped as the A end, it starts a session as host. It waits for a strobe saying the partner's OTG descriptor advertised HNP support, and then raises a request line that asks the surrounding logic to send the b_hnp_enable feature. Once that request is acknowledged, it suspends the bus and watches the partner's DP pull-up. If the pull-up disappears, the A end becomes the peripheral. If a counted number of timeout ticks pass first, it resumes as host.

When strapped as the B end, it starts as a peripheral with its pull-up on. It arms itself only when it has received the enable feature. Once armed, it takes the host role on the next bus suspend by turning its pull-up off. Without the enable, a suspend leaves it a peripheral.

An end-of-session request returns either side to idle. The two line-state inputs (partner pull-up, bus suspended) are asynchronous and pass through a flop chain before use. The state is presented on an encoded output.

Top module: `otg_role_swap`

## Requirements
- R1: After reset, and whenever the state is idle (code 0), pullup_o, suspend_o and feat_req_o are all low.
- R2: From idle, a high sess_start_i moves the state to A-host (code 1) when role_b_i is 0, or to B-peripheral (code 5) when role_b_i is 1. Without sess_start_i the block stays idle.
- R3: In A-host, a high hnp_cap_i moves the state to A-request (code 2), where feat_req_o is high. A feat_ack_i seen in A-host has no effect.
- R4: In A-request, feat_ack_i moves the state to A-suspend (code 3), where suspend_o is high. Loss of the partner pull-up during A-request has no effect.
- R5: In A-suspend, once a low partner_pu_i has passed the SYNC_STAGES synchronizer, the state moves to A-peripheral (code 4) with pullup_o high. This release wins over a timeout expiring on the same cycle.
- R6: In A-suspend with the partner pull-up present, the TMO_TICKS-th tmo_tick_i cycle returns the state to A-host. TMO_TICKS-1 ticks leave it in A-suspend. Ticks in any other state are ignored.
- R7: B-peripheral keeps pullup_o high and stays put through a bus suspend. feat_rx_i moves it to B-armed (code 6), which also keeps pullup_o high.
- R8: In B-armed, a synchronized high bus_susp_i moves the state to B-host (code 7) with pullup_o low.
- R9: end_req_i in any non-idle state returns the state to idle on the next clock.
- R10: Driving rst_n low forces idle with pullup_o low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_b_i | input | 1 | 1 = B end, 0 = A end |
| sess_start_i | input | 1 | Start a session from idle |
| hnp_cap_i | input | 1 | Partner descriptor reports HNP support (A end) |
| feat_ack_i | input | 1 | Enable-feature request was delivered (A end) |
| feat_rx_i | input | 1 | Enable feature received (B end) |
| bus_susp_i | input | 1 | Bus seen suspended (asynchronous) |
| partner_pu_i | input | 1 | Partner DP pull-up present (asynchronous) |
| tmo_tick_i | input | 1 | Suspend-timeout tick |
| end_req_i | input | 1 | End the session |
| state_o | output | 3 | Encoded role state |
| pullup_o | output | 1 | Own DP pull-up enable |
| suspend_o | output | 1 | Bus held suspended by the A end |
| feat_req_o | output | 1 | Request to send the enable feature |

## Verification
The hardest case to reach is a partner pull-up release that lands on the same cycle as the final suspend-timeout tick. The release travels through the synchronizer while the tick does not. The bench therefore parks the controller in A-suspend with all but one tick counted. It then drops partner_pu_i, waits exactly SYNC_STAGES clocks, and pulses the last tick for one cycle, so that both conditions reach the next-state logic together. A separate run stops one tick short of the limit to pin down the timeout boundary.

// File: rtl/otg_swap_pkg.sv
package otg_swap_pkg;
  localparam int unsigned ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE     = 3'd0,
    ST_A_HOST   = 3'd1,
    ST_A_REQ    = 3'd2,
    ST_A_SUSP   = 3'd3,
    ST_A_PERIPH = 3'd4,
    ST_B_PERIPH = 3'd5,
    ST_B_ARMED  = 3'd6,
    ST_B_HOST   = 3'd7
  } role_st_e;
endpackage

// File: rtl/otg_rst_sync.sv
module otg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/otg_line_sync.sv
module otg_line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL[b]}};
      else        sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/otg_susp_timer.sv
module otg_susp_timer #(
  parameter int unsigned TMO_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);
  assign cnt_en   = !run_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)             cnt_d = '0;
    else if (tick_i && !expire_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_swap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     role_b_i,
  input  logic     sess_start_i,
  input  logic     hnp_cap_i,
  input  logic     feat_ack_i,
  input  logic     feat_rx_i,
  input  logic     bus_susp_s_i,
  input  logic     partner_pu_s_i,
  input  logic     tmo_exp_i,
  input  logic     end_req_i,
  output role_st_e st_o,
  output logic     tmr_run_o
);
  role_st_e st_q, st_d;
  logic     st_en;

  always_comb begin
    st_d = st_q;
    if (end_req_i && st_q != ST_IDLE) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:     if (sess_start_i) st_d = role_b_i ? ST_B_PERIPH : ST_A_HOST;
        ST_A_HOST:   if (hnp_cap_i)    st_d = ST_A_REQ;
        ST_A_REQ:    if (feat_ack_i)   st_d = ST_A_SUSP;
        ST_A_SUSP: begin
          if (!partner_pu_s_i)  st_d = ST_A_PERIPH;
          else if (tmo_exp_i)   st_d = ST_A_HOST;
        end
        ST_A_PERIPH: st_d = ST_A_PERIPH;
        ST_B_PERIPH: if (feat_rx_i)    st_d = ST_B_ARMED;
        ST_B_ARMED:  if (bus_susp_s_i) st_d = ST_B_HOST;
        ST_B_HOST:   st_d = ST_B_HOST;
        default:     st_d = ST_IDLE;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign st_o      = st_q;
  assign tmr_run_o = (st_q == ST_A_SUSP);
endmodule

// File: rtl/otg_out_dec.sv
module otg_out_dec
  import otg_swap_pkg::*;
(
  input  role_st_e st_i,
  output logic     pullup_o,
  output logic     suspend_o,
  output logic     feat_req_o
);
  always_comb begin
    pullup_o   = 1'b0;
    suspend_o  = 1'b0;
    feat_req_o = 1'b0;
    unique case (st_i)
      ST_A_REQ:    feat_req_o = 1'b1;
      ST_A_SUSP:   suspend_o  = 1'b1;
      ST_A_PERIPH: pullup_o   = 1'b1;
      ST_B_PERIPH: pullup_o   = 1'b1;
      ST_B_ARMED:  pullup_o   = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/otg_role_swap.sv
module otg_role_swap
  import otg_swap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_TICKS   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            role_b_i,
  input  logic            sess_start_i,
  input  logic            hnp_cap_i,
  input  logic            feat_ack_i,
  input  logic            feat_rx_i,
  input  logic            bus_susp_i,
  input  logic            partner_pu_i,
  input  logic            tmo_tick_i,
  input  logic            end_req_i,
  output logic [ST_W-1:0] state_o,
  output logic            pullup_o,
  output logic            suspend_o,
  output logic            feat_req_o
);
  localparam int unsigned LINE_W = 2;
  localparam logic [LINE_W-1:0] LINE_RST = 2'b10; // pull-up present, bus active

  logic              rst_int_n;
  logic [LINE_W-1:0] line_s;
  logic              tmr_run, tmo_exp;
  role_st_e          st;

  otg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  otg_line_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)) u_line (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({partner_pu_i, bus_susp_i}), .q_o(line_s)
  );

  otg_susp_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_int_n),
    .run_i(tmr_run), .tick_i(tmo_tick_i), .expire_o(tmo_exp)
  );

  otg_role_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .role_b_i(role_b_i), .sess_start_i(sess_start_i),
    .hnp_cap_i(hnp_cap_i), .feat_ack_i(feat_ack_i), .feat_rx_i(feat_rx_i),
    .bus_susp_s_i(line_s[0]), .partner_pu_s_i(line_s[1]),
    .tmo_exp_i(tmo_exp), .end_req_i(end_req_i),
    .st_o(st), .tmr_run_o(tmr_run)
  );

  otg_out_dec u_dec (
    .st_i(st), .pullup_o(pullup_o), .suspend_o(suspend_o), .feat_req_o(feat_req_o)
  );

  assign state_o = st;
endmodule

// File: rtl/otg_role_swap_chk.sv
module otg_role_swap_chk
  import otg_swap_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sess_start_i,
  input logic            feat_rx_i,
  input logic            end_req_i,
  input logic [ST_W-1:0] state_o,
  input logic            pullup_o,
  input logic            suspend_o,
  input logic            feat_req_o
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_IDLE |-> !pullup_o && !suspend_o && !feat_req_o);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_IDLE && !sess_start_i |=> state_o == ST_IDLE);

  a_r4_susp_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_A_SUSP && $past(state_o) != ST_A_SUSP |-> $past(state_o) == ST_A_REQ);

  a_r5_periph_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_A_PERIPH && $past(state_o) != ST_A_PERIPH |-> $past(state_o) == ST_A_SUSP);

  a_r7_b_stays_periph: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_B_PERIPH && !feat_rx_i && !end_req_i |=> state_o == ST_B_PERIPH && pullup_o);

  a_r8_bhost_entry: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_B_HOST && $past(state_o) != ST_B_HOST |-> $past(state_o) == ST_B_ARMED);

  a_r9_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    end_req_i && state_o != ST_IDLE |=> state_o == ST_IDLE);
endmodule

bind otg_role_swap otg_role_swap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sess_start_i(sess_start_i), .feat_rx_i(feat_rx_i),
  .end_req_i(end_req_i), .state_o(state_o), .pullup_o(pullup_o),
  .suspend_o(suspend_o), .feat_req_o(feat_req_o)
);

// File: tb/tb_otg_role_swap.sv
`timescale 1ns/100ps
module tb_otg_role_swap;
  localparam int SYNC = 2;
  localparam int TMO  = 3;
  localparam int HOLD = 4;
  localparam int NV   = 21;

  logic clk, rst_n;
  logic [8:0] in_v; // {role_b, sess, cap, ack, frx, susp, pu, tick, endr}
  logic [2:0] state_o;
  logic pullup_o, suspend_o, feat_req_o;
  int nchk, nfail;
  bit done;

  otg_role_swap #(.SYNC_STAGES(SYNC), .TMO_TICKS(TMO)) dut (
    .clk(clk), .rst_n(rst_n),
    .role_b_i(in_v[8]), .sess_start_i(in_v[7]), .hnp_cap_i(in_v[6]),
    .feat_ack_i(in_v[5]), .feat_rx_i(in_v[4]), .bus_susp_i(in_v[3]),
    .partner_pu_i(in_v[2]), .tmo_tick_i(in_v[1]), .end_req_i(in_v[0]),
    .state_o(state_o), .pullup_o(pullup_o), .suspend_o(suspend_o), .feat_req_o(feat_req_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req[3:0], inputs[8:0], state[2:0], pullup, suspend, feat_req}
  localparam logic [18:0] VEC [NV] = '{
    {4'd2,  9'b0_1_0_0_0_0_1_0_0, 3'd1, 3'b000}, // R2 A session start
    {4'd3,  9'b0_0_0_1_0_0_1_0_0, 3'd1, 3'b000}, // R3 ack ignored in A-host
    {4'd3,  9'b0_0_1_0_0_0_1_0_0, 3'd2, 3'b001}, // R3 descriptor -> request
    {4'd4,  9'b0_0_0_0_0_0_0_0_0, 3'd2, 3'b001}, // R4 pull-up loss ignored
    {4'd4,  9'b0_0_0_0_0_0_1_0_0, 3'd2, 3'b001}, // R4
    {4'd4,  9'b0_0_0_1_0_0_1_0_0, 3'd3, 3'b010}, // R4 ack -> suspend
    {4'd6,  9'b0_0_0_0_0_0_1_1_0, 3'd1, 3'b000}, // R6 timeout -> host
    {4'd3,  9'b0_0_1_0_0_0_1_0_0, 3'd2, 3'b001}, // R3
    {4'd4,  9'b0_0_0_1_0_0_1_0_0, 3'd3, 3'b010}, // R4
    {4'd5,  9'b0_0_0_0_0_0_0_0_0, 3'd4, 3'b100}, // R5 release -> peripheral
    {4'd6,  9'b0_0_0_0_0_0_0_1_0, 3'd4, 3'b100}, // R6 ticks ignored elsewhere
    {4'd9,  9'b0_0_0_0_0_0_0_0_1, 3'd0, 3'b000}, // R9 end of session
    {4'd1,  9'b0_0_0_0_0_0_1_0_0, 3'd0, 3'b000}, // R1 idle quiet
    {4'd2,  9'b1_1_0_0_0_0_1_0_0, 3'd5, 3'b100}, // R2 B session start
    {4'd7,  9'b1_0_0_0_0_1_1_0_0, 3'd5, 3'b100}, // R7 suspend without enable
    {4'd7,  9'b1_0_0_0_0_0_1_0_0, 3'd5, 3'b100}, // R7
    {4'd7,  9'b1_0_0_0_1_0_1_0_0, 3'd6, 3'b100}, // R7 enable -> armed
    {4'd8,  9'b1_0_0_0_0_1_1_0_0, 3'd7, 3'b000}, // R8 suspend -> host
    {4'd8,  9'b1_0_0_0_0_0_1_0_0, 3'd7, 3'b000}, // R8
    {4'd9,  9'b1_0_0_0_0_0_1_0_1, 3'd0, 3'b000}, // R9
    {4'd2,  9'b1_0_0_0_0_0_1_0_0, 3'd0, 3'b000}  // R2 idle without start
  };

  task automatic check(input int req, input logic [5:0] exp);
    nchk++;
    if ({state_o, pullup_o, suspend_o, feat_req_o} !== exp) begin
      nfail++;
      $display("FAIL R%0d: got %b expected %b", req,
               {state_o, pullup_o, suspend_o, feat_req_o}, exp);
    end
  endtask

  task automatic settle(input logic [8:0] v);
    in_v = v;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_pulse();
    in_v[1] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_v[1] = 1'b0;
  endtask

  initial begin
    nchk = 0; nfail = 0; done = 0;
    in_v = 9'b0_0_0_0_0_0_1_0_0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 6'b000_000); // R1 reset state
    rst_n = 1'b1;
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      settle(VEC[i][14:6]);
      check(int'(VEC[i][18:15]), VEC[i][5:0]);
    end

    // R6: one tick short of the limit stays suspended, the last tick expires
    settle(9'b0_1_0_0_0_0_1_0_0);
    settle(9'b0_0_1_0_0_0_1_0_0);
    settle(9'b0_0_0_1_0_0_1_0_0);
    settle(9'b0_0_0_0_0_0_1_0_0);
    check(4, 6'b011_010); // R4
    for (int k = 0; k < TMO - 1; k++) tick_pulse();
    repeat (HOLD) @(negedge clk);
    check(6, 6'b011_010); // R6 boundary
    tick_pulse();
    check(6, 6'b001_000); // R6 expiry

    // R5: release reaches the FSM on the cycle of the final tick
    settle(9'b0_0_1_0_0_0_1_0_0);
    settle(9'b0_0_0_1_0_0_1_0_0);
    settle(9'b0_0_0_0_0_0_1_0_0);
    for (int k = 0; k < TMO - 1; k++) tick_pulse();
    in_v[2] = 1'b0;
    repeat (SYNC) @(posedge clk);
    @(negedge clk);
    check(5, 6'b011_010); // R5 still suspended before coincidence
    tick_pulse();
    check(5, 6'b100_100); // R5 release wins
    settle(9'b0_0_0_0_0_0_0_0_1);
    check(9, 6'b000_000); // R9
    settle(9'b0_0_0_0_0_0_1_0_0);

    // R10: asynchronous reset while B is host
    settle(9'b1_1_0_0_0_0_1_0_0);
    settle(9'b1_0_0_0_1_0_1_0_0);
    settle(9'b1_0_0_0_0_1_1_0_0);
    check(8, 6'b111_000); // R8
    settle(9'b1_0_0_0_0_0_1_0_0);
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5 check(10, 6'b000_000); // R10 immediate
    @(negedge clk);
    rst_n = 1'b1;
    repeat (SYNC + 2) @(posedge clk);
    @(negedge clk);
    check(10, 6'b000_000); // R10 idle after release

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule